// File: doc/BRIEF.md
# 64-bit Virtual Address Segment Translator

This block is the address check stage of a 64-bit processor pipeline. Each request carries a virtual address, an access kind (instruction fetch, data load or data store) and an access size (byte, half, word or double). The block looks at the top region bits of the address and checks natural alignment. It then returns either a physical address or an address-error fault, together with the faulting address. Only two kinds of region translate. The first is the direct physical window. The second is a pair of unmapped 32-bit compatibility kernel windows. Every mapped region faults, because no translation table exists behind this stage.

Requests enter over a valid/ready stream and results leave over a second valid/ready stream. A single output register sits between them. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle (`rsp_valid && rsp_ready`). A result the consumer does not take stays in place and keeps all its fields until `rsp_ready` rises. Results come out in the order their requests were accepted, one for each request.

Top module: `seg_xlate`

## Requirements
- R1: During reset and after its release, before any request is taken, `rsp_valid` is 0 and `req_ready` is 1.
- R2: When address bits 63:62 are 10 (physical window), the result carries no fault and its physical address is bits 58:0 zero-extended. Bits 61:59 have no effect on the result.
- R3: When bits 63:62 are 11, bits 61:31 are all ones and bits 30:29 are 00 or 01, the result carries no fault and its physical address is bits 28:0 zero-extended.
- R4: Any other address with bits 63:62 = 11 faults. This covers bits 30:29 of 10 or 11, and any zero anywhere in bits 61:31.
- R5: Addresses with bits 63:62 of 00 (user) or 01 (supervisor) always fault.
- R6: The fault code is 0x05 when the kind is store (`req_kind` = 10). It is 0x04 for fetch (00), load (01) and the spare kind value 11.
- R7: With `req_size` 0 = byte, 1 = half, 2 = word and 3 = double, an access faults if address bits [size-1:0] are not all zero. This applies even in a region that would otherwise translate, and the fault uses the code from R6.
- R8: On a fault, `rsp_paddr` is zero and `rsp_badaddr` is the request's virtual address. With no fault, `rsp_code` and `rsp_badaddr` are zero.
- R9: A result becomes valid in the cycle right after the edge that accepted its request.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and every result field keeps its value. `req_ready` equals `!rsp_valid || rsp_ready`. Each accepted request yields exactly one result, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_kind | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 treated as load |
| req_size | input | 2 | Access size as log2 of bytes |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_fault | output | 1 | Address error raised |
| rsp_code | output | 5 | Fault code (0x04 load/fetch, 0x05 store, 0 when no fault) |
| rsp_paddr | output | 64 | Physical address, zero on fault |
| rsp_badaddr | output | 64 | Faulting virtual address, zero when no fault |

## Verification
Every result is due exactly one cycle after the edge that accepted its request. The bench records the cycle count at acceptance next to the expected item in its scoreboard. The monitor compares that count with the cycle in which the matching result first appears. The monitor samples in the middle of the low clock phase. It pops an item only when valid and ready are both high, so a result is compared once, on the edge where it is taken. During stalls it checks, in every stalled cycle, that the held result matches the one sampled the cycle before.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int unsigned ADDR_W = 64;
  localparam int unsigned CODE_W = 5;

  typedef enum logic [1:0] {
    RGN_USER  = 2'b00,
    RGN_SUPER = 2'b01,
    RGN_PHYS  = 2'b10,
    RGN_KERN  = 2'b11
  } region_e;

  localparam logic [1:0] KIND_STORE = 2'b10;

  localparam logic [CODE_W-1:0] CODE_NONE  = 5'h00;
  localparam logic [CODE_W-1:0] CODE_LOAD  = 5'h04;
  localparam logic [CODE_W-1:0] CODE_STORE = 5'h05;

endpackage

// File: rtl/seg_decode.sv
module seg_decode #(
  parameter int unsigned VA_W     = 64,
  parameter int unsigned WIN_W    = 59,
  parameter int unsigned COMPAT_W = 29
) (
  input  logic [VA_W-1:0] vaddr,
  output logic            hit,
  output logic [VA_W-1:0] paddr
);
  import seg_xlate_pkg::*;

  localparam int unsigned SEL_LO    = VA_W - 2;
  localparam int unsigned PREFIX_HI = VA_W - 3;
  localparam int unsigned PREFIX_LO = COMPAT_W + 2;

  region_e    region;
  logic       prefix_ones;
  logic [1:0] sub_sel;

  assign region      = region_e'(vaddr[VA_W-1:SEL_LO]);
  assign prefix_ones = &vaddr[PREFIX_HI:PREFIX_LO];
  assign sub_sel     = vaddr[COMPAT_W+1:COMPAT_W];

  always_comb begin
    hit   = 1'b0;
    paddr = '0;
    unique case (region)
      RGN_PHYS: begin
        hit   = 1'b1;
        paddr = VA_W'(vaddr[WIN_W-1:0]);
      end
      RGN_KERN: begin
        // only the two lower compatibility windows bypass translation
        hit   = prefix_ones && !sub_sel[1];
        paddr = VA_W'(vaddr[COMPAT_W-1:0]);
      end
      RGN_USER, RGN_SUPER: begin
        hit   = 1'b0;
        paddr = '0;
      end
      default: begin
        hit   = 1'b0;
        paddr = '0;
      end
    endcase
  end

endmodule

// File: rtl/align_check.sv
module align_check #(
  parameter int unsigned SIZE_W = 2
) (
  input  logic [SIZE_W-1:0]               size,
  input  logic [(1<<SIZE_W)-2:0]          offs,
  output logic                            misaligned
);
  localparam int unsigned OFFS_W = (1 << SIZE_W) - 1;

  logic [OFFS_W-1:0] need_zero;

  for (genvar i = 0; i < OFFS_W; i++) begin : g_bit
    assign need_zero[i] = (size > SIZE_W'(i));
  end

  assign misaligned = |(offs & need_zero);

endmodule

// File: rtl/err_code_sel.sv
module err_code_sel
  import seg_xlate_pkg::*;
(
  input  logic [1:0]        kind,
  output logic [CODE_W-1:0] code
);
  assign code = (kind == KIND_STORE) ? CODE_STORE : CODE_LOAD;
endmodule

// File: rtl/rsp_stage.sv
module rsp_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W     = ADDR_W,
  parameter int unsigned WIN_W    = 59,
  parameter int unsigned COMPAT_W = 29,
  parameter int unsigned SIZE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic [SIZE_W-1:0] req_size,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [CODE_W-1:0] rsp_code,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [VA_W-1:0]   rsp_badaddr
);
  localparam int unsigned OFFS_W = (1 << SIZE_W) - 1;
  localparam int unsigned PAY_W  = 1 + CODE_W + 2 * VA_W;

  logic              seg_hit;
  logic [VA_W-1:0]   seg_pa;
  logic              misaligned;
  logic [CODE_W-1:0] err_code;
  logic              fault;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  seg_decode #(.VA_W(VA_W), .WIN_W(WIN_W), .COMPAT_W(COMPAT_W)) u_decode (
    .vaddr (req_vaddr),
    .hit   (seg_hit),
    .paddr (seg_pa)
  );

  align_check #(.SIZE_W(SIZE_W)) u_align (
    .size       (req_size),
    .offs       (req_vaddr[OFFS_W-1:0]),
    .misaligned (misaligned)
  );

  err_code_sel u_code (
    .kind (req_kind),
    .code (err_code)
  );

  // alignment fault wins over the region result
  assign fault  = misaligned || !seg_hit;
  assign pay_in = {fault,
                   fault ? err_code : CODE_NONE,
                   fault ? '0 : seg_pa,
                   fault ? req_vaddr : '0};

  rsp_stage #(.W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pay_in),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (pay_out)
  );

  assign {rsp_fault, rsp_code, rsp_paddr, rsp_badaddr} = pay_out;

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R9
  AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0); // R8
  AST_FAULT_CODE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> (rsp_code == CODE_LOAD || rsp_code == CODE_STORE)); // R6
  AST_CLEAN_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> (rsp_code == CODE_NONE && rsp_badaddr == '0)); // R8
  AST_PA_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[VA_W-1:WIN_W] == '0); // R2

endmodule

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;

  typedef struct {
    logic        fault;
    logic [4:0]  code;
    logic [63:0] pa;
    logic [63:0] bad;
    int          acc;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;
  logic [4:0]  rsp_code;
  logic [63:0] rsp_paddr;
  logic [63:0] rsp_badaddr;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   stall_mode = 1'b0;
  bit   finished = 1'b0;
  exp_t sb[$];

  seg_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_code(rsp_code), .rsp_paddr(rsp_paddr), .rsp_badaddr(rsp_badaddr)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic exp_t model(logic [63:0] v, logic [1:0] k, logic [1:0] s, string tag);
    exp_t e;
    logic mis, ok;
    logic [63:0] pa;
    mis = (s == 2'd1 && v[0]) || (s == 2'd2 && v[1:0] != 2'b00) ||
          (s == 2'd3 && v[2:0] != 3'b000);
    ok = 1'b0;
    pa = '0;
    if (v[63:62] == 2'b10) begin
      ok = 1'b1;
      pa = {5'b0, v[58:0]};
    end else if (v[63:62] == 2'b11 && (&v[61:31]) && !v[30]) begin
      ok = 1'b1;
      pa = {35'b0, v[28:0]};
    end
    e.fault = mis || !ok;
    e.code  = e.fault ? ((k == 2'b10) ? 5'h05 : 5'h04) : 5'h00;
    e.pa    = e.fault ? 64'd0 : pa;
    e.bad   = e.fault ? v : 64'd0;
    e.acc   = 0;
    e.tag   = tag;
    return e;
  endfunction

  task automatic send(logic [63:0] v, logic [1:0] k, logic [1:0] s, string tag);
    exp_t e;
    @(negedge clk);
    #2;
    req_valid = 1'b1;
    req_vaddr = v;
    req_kind  = k;
    req_size  = s;
    forever begin
      #2;
      if (req_ready) break;
      @(negedge clk);
      #2;
    end
    e = model(v, k, s, tag);
    e.acc = cyc;
    sb.push_back(e);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // consumer ready pattern
  initial forever begin
    @(negedge clk);
    #1 rsp_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor: scoreboard compare, timing and stall hold
  initial begin
    bit          p_valid = 0, p_hs = 0, p_stall = 0;
    logic [133:0] p_pay = '0;
    logic [133:0] pay;
    int          first_cyc = 0;
    exp_t        e;
    forever begin
      @(negedge clk);
      #5;
      pay = {rsp_fault, rsp_code, rsp_paddr, rsp_badaddr};
      if (rst_n) begin
        if (p_stall) begin
          checks++;
          if (!rsp_valid || pay !== p_pay) begin
            errors++;
            $display("FAIL R10 hold: valid=%0b data=%h expected held data=%h", rsp_valid, pay, p_pay);
          end
        end
        if (rsp_valid && (!p_valid || p_hs)) first_cyc = cyc;
        if (rsp_valid && rsp_ready) begin
          if (sb.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R10 unexpected result: data=%h expected none", pay);
          end else begin
            e = sb.pop_front();
            checks++;
            if (rsp_fault !== e.fault || rsp_code !== e.code ||
                rsp_paddr !== e.pa || rsp_badaddr !== e.bad) begin
              errors++;
              $display("FAIL %s: got fault=%0b code=%h pa=%h bad=%h expected fault=%0b code=%h pa=%h bad=%h",
                       e.tag, rsp_fault, rsp_code, rsp_paddr, rsp_badaddr,
                       e.fault, e.code, e.pa, e.bad);
            end
            checks++;
            if (first_cyc != e.acc + 1) begin
              errors++;
              $display("FAIL R9 latency (%s): result at cycle %0d expected %0d", e.tag, first_cyc, e.acc + 1);
            end
          end
        end
        p_valid = rsp_valid;
        p_hs    = rsp_valid && rsp_ready;
        p_stall = rsp_valid && !rsp_ready;
        p_pay   = pay;
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run still busy at cycle %0d, expected completion", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: rsp_valid=%b expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #3;
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 after reset: rsp_valid=%b req_ready=%b expected 0 1", rsp_valid, req_ready);
    end

    // R2 physical window, cache bits ignored
    send(64'h8000_0000_0000_1000, 2'b01, 2'd2, "R2 plain");
    send(64'hB800_0000_1234_5678, 2'b00, 2'd2, "R2 cache bits");
    send(64'h8400_0000_0000_0008, 2'b10, 2'd3, "R2 top window bit");
    // R3 compatibility windows
    send(64'hFFFF_FFFF_8000_0010, 2'b01, 2'd3, "R3 window 00");
    send(64'hFFFF_FFFF_BFC0_0000, 2'b00, 2'd2, "R3 window 01");
    // R4 other kernel addresses
    send(64'hFFFF_FFFF_C000_0000, 2'b01, 2'd2, "R4 window 10");
    send(64'hFFFF_FFFF_E000_0000, 2'b10, 2'd2, "R4 window 11");
    send(64'hFFFF_FFFE_8000_0000, 2'b01, 2'd0, "R4 prefix hole");
    send(64'hC000_0000_0000_0000, 2'b00, 2'd3, "R4 low kernel");
    // R5 user and supervisor
    send(64'h0000_0000_0040_0000, 2'b01, 2'd2, "R5 user");
    send(64'h4000_0000_0000_0000, 2'b10, 2'd0, "R5 supervisor");
    // R6 code by kind
    send(64'h0000_0000_0000_0100, 2'b00, 2'd0, "R6 fetch");
    send(64'h0000_0000_0000_0100, 2'b11, 2'd0, "R6 spare kind");
    send(64'h0000_0000_0000_0100, 2'b10, 2'd0, "R6 store");
    // R7 alignment, priority over region
    send(64'h8000_0000_0000_0002, 2'b10, 2'd2, "R7 word misaligned store");
    send(64'h8000_0000_0000_0003, 2'b01, 2'd1, "R7 half odd");
    send(64'hFFFF_FFFF_8000_0004, 2'b01, 2'd3, "R7 double at 4");
    send(64'h8000_0000_0000_0007, 2'b01, 2'd0, "R7 byte any");
    send(64'h8000_0000_0000_0006, 2'b00, 2'd1, "R7 half even");
    send(64'h0000_0000_0000_0001, 2'b10, 2'd1, "R7 R8 misaligned in user");

    // R10 back-pressure with mixed stimulus
    stall_mode = 1'b1;
    for (int n = 0; n < 60; n++) begin
      logic [63:0] base, v;
      case ($urandom % 5)
        0: base = 64'h8000_0000_0000_0000;
        1: base = 64'hFFFF_FFFF_8000_0000;
        2: base = 64'hFFFF_FFFF_A000_0000;
        3: base = 64'hFFFF_FFFF_C000_0000;
        default: base = 64'h0000_0000_1000_0000;
      endcase
      v = base | {48'd0, 16'($urandom)} | (base[63] ? {2'b0, 3'($urandom), 59'd0} : 64'd0);
      send(v, 2'($urandom), 2'($urandom), "R10 R8 stream");
    end
    stall_mode = 1'b0;

    wait (sb.size() == 0);
    repeat (3) @(negedge clk);
    #5;
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 extra result: rsp_valid=%b expected 0", rsp_valid);
    end
    finish_run();
  end

endmodule